// File: doc/BRIEF.md
# Variable-Length Instruction Byte Parser

The parser accepts a stream of instruction bytes, one per valid/ready handshake, for a 16-bit two-operand instruction encoding whose length runs from one to six bytes. From the leading byte it pulls out a six-bit operation code, a direction flag and a width flag. A small built-in opcode table sorts that byte into one of six format classes. The class decides whether an addressing byte follows and whether immediate bytes follow. The addressing byte, when present, yields the mode, register and register/memory fields.

The mode and register/memory fields set how many displacement bytes come next. The class and the width flag set how many immediate bytes come after those. Multi-byte values arrive low byte first. Once the last byte of an instruction is taken, the parser presents one decoded record with the total byte count. It holds that record until a consumer accepts it, and refuses further bytes while it waits.

The block sits between an instruction byte queue and a decode stage. It absorbs the length discovery so that the decode stage sees whole instructions.

Top module: `insn_byte_parser`

## Requirements
- R1: The record carries the leading byte's bits 7..2 as the opcode, bit 1 as the direction flag (1 = register field names the destination) and bit 0 as the width flag (0 = byte, 1 = word).
- R2: The class output uses these codes, chosen by the leading byte. 2 (addressing byte, no immediate) for 0x00-0x3F with bit 2 = 0 and for 0x84-0x8B. 4 (accumulator immediate) for 0x00-0x3F with bits 2..1 = 10. 1 (register in opcode) for 0x40-0x5F and 0x90-0x97. 3 (addressing byte plus immediate) for 0x80-0x83, 0xC6 and 0xC7. 5 (direct address) for 0xA0-0xA3. 0 (plain single byte) for every other value.
- R3: For classes 2 and 3, the second byte supplies mode = bits 7..6, register = bits 5..3 and register/memory = bits 2..0. A mode of 11 adds no displacement byte: 0x88 0xC1 gives mode 3, register 0, register/memory 1, length 2, and 0x8B 0x07 gives mode 0, register 0, register/memory 7, direction 1, width 1, length 2.
- R4: The displacement byte count is 1 for mode 01, 2 for mode 10, 2 for mode 00 with register/memory 110, and 0 otherwise. A single displacement byte is sign-extended to 16 bits, and two bytes are joined low byte first.
- R5: Classes 3 and 4 append immediate bytes after any displacement: one byte zero-extended when the width flag is 0, two bytes low byte first when it is 1.
- R6: Class 1 reports the register as the leading byte's bits 2..0 and has length 1.
- R7: The register-valid output is 1 for classes 1 and 2 and 0 for all others. In class 3 the register bits are an opcode extension.
- R8: Class 5 takes two address bytes, low byte first, into the displacement output, for a length of 3.
- R9: The length output equals the number of bytes consumed for the instruction, from 1 to 6.
- R10: A presented record keeps all of its fields stable until rec_ready_i is high at a clock edge. While a record is presented, in_ready_o is low and no byte is consumed.
- R11: Reset clears any partial instruction: afterwards in_ready_o is 1, rec_valid_o is 0, and the next byte is treated as a leading byte.
- R12: Fields the instruction does not carry read as zero: mode and register/memory without an addressing byte, register for classes 0, 4 and 5, and the displacement and immediate when absent.
- R13: rec_valid_o rises in the cycle after the clock edge that consumes the instruction's last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Byte offered |
| in_byte_i | input | 8 | Instruction byte |
| in_ready_o | output | 1 | Parser can take a byte |
| rec_valid_o | output | 1 | Decoded record presented |
| rec_ready_i | input | 1 | Consumer takes the record |
| rec_class_o | output | 3 | Format class code |
| rec_opcode_o | output | 6 | Opcode bits |
| rec_dir_o | output | 1 | Direction flag |
| rec_wide_o | output | 1 | Width flag |
| rec_mod_o | output | 2 | Mode field |
| rec_reg_o | output | 3 | Register field |
| rec_reg_valid_o | output | 1 | Register field names a register |
| rec_rm_o | output | 3 | Register/memory field |
| rec_disp_o | output | 16 | Displacement or direct address |
| rec_imm_o | output | 16 | Immediate value |
| rec_len_o | output | 3 | Total instruction length in bytes |

## Verification
A record is due in the cycle after the edge that takes its final byte. The driver checks rec_valid_o at the falling edge that follows the last accepted byte. The record leaves one edge after rec_ready_i is seen high, and in_ready_o returns in that same cycle. The monitor therefore compares fields only at falling edges where both rec_valid_o and rec_ready_i are high, and between those edges it checks that a stalled record has not changed and that in_ready_o stays low.

// File: rtl/ibp_pkg.sv
`timescale 1ns/1ps
package ibp_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int OPC_W  = BYTE_W - 2;
  localparam int FLD_W  = 3;
  localparam int MOD_W  = 2;
  localparam int LEN_W  = 3;
  localparam int CNT_W  = 2;

  typedef enum logic [2:0] {
    CLS_PLAIN     = 3'd0,
    CLS_REG1      = 3'd1,
    CLS_MODRM     = 3'd2,
    CLS_MODRM_IMM = 3'd3,
    CLS_ACC_IMM   = 3'd4,
    CLS_DIRECT    = 3'd5
  } insn_cls_e;

  typedef enum logic [2:0] {
    ST_OP, ST_MODRM, ST_DISP, ST_IMM, ST_OUT
  } pst_e;
endpackage

// File: rtl/ibp_class_lut.sv
`timescale 1ns/1ps
module ibp_class_lut
  import ibp_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output insn_cls_e         cls_o
);
  always_comb begin
    cls_o = CLS_PLAIN;
    if (byte_i[7:6] == 2'b00) begin
      if (!byte_i[2])                cls_o = CLS_MODRM;
      else if (byte_i[2:1] == 2'b10) cls_o = CLS_ACC_IMM;
    end else if (byte_i[7:5] == 3'b010 || byte_i[7:3] == 5'b10010) begin
      cls_o = CLS_REG1;
    end else if (byte_i[7:2] == 6'b100000 || byte_i[7:1] == 7'b1100011) begin
      cls_o = CLS_MODRM_IMM;
    end else if (byte_i[7:2] == 6'b100001 || byte_i[7:2] == 6'b100010) begin
      cls_o = CLS_MODRM;
    end else if (byte_i[7:2] == 6'b101000) begin
      cls_o = CLS_DIRECT;
    end
  end
endmodule

// File: rtl/ibp_len_calc.sv
`timescale 1ns/1ps
module ibp_len_calc
  import ibp_pkg::*;
(
  input  insn_cls_e        cls_i,
  input  logic             wide_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic [FLD_W-1:0] rm_i,
  output logic             has_modrm_o,
  output logic [CNT_W-1:0] disp_n_o,
  output logic [CNT_W-1:0] imm_n_o,
  output logic             sext_o
);
  always_comb begin
    has_modrm_o = (cls_i == CLS_MODRM) || (cls_i == CLS_MODRM_IMM);
    disp_n_o    = '0;
    sext_o      = 1'b0;
    if (cls_i == CLS_DIRECT) begin
      disp_n_o = 2'd2;
    end else if (has_modrm_o) begin
      unique case (mod_i)
        2'b01:   begin disp_n_o = 2'd1; sext_o = 1'b1; end
        2'b10:   disp_n_o = 2'd2;
        2'b00:   disp_n_o = (rm_i == 3'b110) ? 2'd2 : 2'd0;
        default: disp_n_o = 2'd0;
      endcase
    end
    imm_n_o = ((cls_i == CLS_MODRM_IMM) || (cls_i == CLS_ACC_IMM))
              ? (wide_i ? 2'd2 : 2'd1) : 2'd0;
  end
endmodule

// File: rtl/ibp_word_gather.sv
`timescale 1ns/1ps
module ibp_word_gather #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          ld_i,
  input  logic          hi_i,
  input  logic          sext_i,
  input  logic [BW-1:0] byte_i,
  output logic [2*BW-1:0] word_o
);
  logic [BW-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (clr_i) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (ld_i) begin
      if (hi_i) begin
        hi_q <= byte_i;
      end else begin
        lo_q <= byte_i;
        hi_q <= sext_i ? {BW{byte_i[BW-1]}} : '0;
      end
    end
  end

  assign word_o = {hi_q, lo_q};
endmodule

// File: rtl/insn_byte_parser.sv
`timescale 1ns/1ps
module insn_byte_parser
  import ibp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_byte_i,
  output logic              in_ready_o,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output logic [2:0]        rec_class_o,
  output logic [OPC_W-1:0]  rec_opcode_o,
  output logic              rec_dir_o,
  output logic              rec_wide_o,
  output logic [MOD_W-1:0]  rec_mod_o,
  output logic [FLD_W-1:0]  rec_reg_o,
  output logic              rec_reg_valid_o,
  output logic [FLD_W-1:0]  rec_rm_o,
  output logic [WORD_W-1:0] rec_disp_o,
  output logic [WORD_W-1:0] rec_imm_o,
  output logic [LEN_W-1:0]  rec_len_o
);
  pst_e              st_q;
  insn_cls_e         cls_q, cls_in, cls_sel;
  logic [BYTE_W-1:0] op_q, modrm_q;
  logic [CNT_W-1:0]  disp_n_q, imm_n_q, cnt_q, cnt_inc;
  logic [LEN_W-1:0]  len_q;
  logic              sext_q;
  logic              acc, wide_sel;
  logic              lc_modrm, lc_sext;
  logic [CNT_W-1:0]  lc_disp_n, lc_imm_n;

  assign in_ready_o = (st_q != ST_OUT);
  assign acc        = in_valid_i && in_ready_o;
  assign cnt_inc    = cnt_q + 1'b1;

  ibp_class_lut u_lut (.byte_i(in_byte_i), .cls_o(cls_in));

  assign cls_sel  = (st_q == ST_OP) ? cls_in : cls_q;
  assign wide_sel = (st_q == ST_OP) ? in_byte_i[0] : op_q[0];

  ibp_len_calc u_len (
    .cls_i      (cls_sel),
    .wide_i     (wide_sel),
    .mod_i      (in_byte_i[7:6]),
    .rm_i       (in_byte_i[2:0]),
    .has_modrm_o(lc_modrm),
    .disp_n_o   (lc_disp_n),
    .imm_n_o    (lc_imm_n),
    .sext_o     (lc_sext)
  );

  function automatic pst_e after_hdr(input logic [CNT_W-1:0] dn, input logic [CNT_W-1:0] in_n);
    if (dn != '0)        return ST_DISP;
    else if (in_n != '0) return ST_IMM;
    else                 return ST_OUT;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_OP;
      cls_q    <= CLS_PLAIN;
      op_q     <= '0;
      modrm_q  <= '0;
      disp_n_q <= '0;
      imm_n_q  <= '0;
      cnt_q    <= '0;
      len_q    <= '0;
      sext_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_OP: if (acc) begin
          op_q    <= in_byte_i;
          cls_q   <= cls_in;
          modrm_q <= '0;
          len_q   <= LEN_W'(1);
          cnt_q   <= '0;
          sext_q  <= 1'b0;
          imm_n_q <= lc_imm_n;
          if (lc_modrm) begin
            disp_n_q <= '0;
            st_q     <= ST_MODRM;
          end else begin
            disp_n_q <= lc_disp_n;
            st_q     <= after_hdr(lc_disp_n, lc_imm_n);
          end
        end
        ST_MODRM: if (acc) begin
          modrm_q  <= in_byte_i;
          len_q    <= len_q + 1'b1;
          disp_n_q <= lc_disp_n;
          sext_q   <= lc_sext;
          st_q     <= after_hdr(lc_disp_n, imm_n_q);
        end
        ST_DISP: if (acc) begin
          len_q <= len_q + 1'b1;
          if (cnt_inc == disp_n_q) begin
            cnt_q <= '0;
            st_q  <= (imm_n_q != '0) ? ST_IMM : ST_OUT;
          end else begin
            cnt_q <= cnt_inc;
          end
        end
        ST_IMM: if (acc) begin
          len_q <= len_q + 1'b1;
          if (cnt_inc == imm_n_q) begin
            cnt_q <= '0;
            st_q  <= ST_OUT;
          end else begin
            cnt_q <= cnt_inc;
          end
        end
        ST_OUT: if (rec_ready_i) st_q <= ST_OP;
        default: st_q <= ST_OP;
      endcase
    end
  end

  logic new_insn;
  assign new_insn = (st_q == ST_OP) && acc;

  ibp_word_gather #(.BW(BYTE_W)) u_disp (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(new_insn),
    .ld_i  ((st_q == ST_DISP) && acc), .hi_i(cnt_q[0]),
    .sext_i(sext_q), .byte_i(in_byte_i), .word_o(rec_disp_o)
  );

  ibp_word_gather #(.BW(BYTE_W)) u_imm (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(new_insn),
    .ld_i  ((st_q == ST_IMM) && acc), .hi_i(cnt_q[0]),
    .sext_i(1'b0), .byte_i(in_byte_i), .word_o(rec_imm_o)
  );

  logic has_modrm_q;
  assign has_modrm_q = (cls_q == CLS_MODRM) || (cls_q == CLS_MODRM_IMM);

  assign rec_valid_o     = (st_q == ST_OUT);
  assign rec_class_o     = cls_q;
  assign rec_opcode_o    = op_q[7:2];
  assign rec_dir_o       = op_q[1];
  assign rec_wide_o      = op_q[0];
  assign rec_mod_o       = modrm_q[7:6];
  assign rec_rm_o        = modrm_q[2:0];
  assign rec_reg_o       = (cls_q == CLS_REG1) ? op_q[2:0]
                         : (has_modrm_q ? modrm_q[5:3] : '0);
  assign rec_reg_valid_o = (cls_q == CLS_REG1) || (cls_q == CLS_MODRM);
  assign rec_len_o       = len_q;
endmodule

// File: rtl/ibp_checker.sv
`timescale 1ns/1ps
module ibp_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_ready_o,
  input logic        rec_valid_o,
  input logic        rec_ready_i,
  input logic [2:0]  rec_class_o,
  input logic [5:0]  rec_opcode_o,
  input logic [1:0]  rec_mod_o,
  input logic        rec_reg_valid_o,
  input logic [15:0] rec_disp_o,
  input logic [15:0] rec_imm_o,
  input logic [2:0]  rec_len_o
);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_len_o) && $stable(rec_disp_o)
      && $stable(rec_imm_o) && $stable(rec_opcode_o) && $stable(rec_class_o));

  p_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> !in_ready_o);

  p_len_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_len_o >= 3'd1) && (rec_len_o <= 3'd6));

  p_opext_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && (rec_class_o == 3'd3) |-> !rec_reg_valid_o);

  p_sext_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && (rec_class_o == 3'd2 || rec_class_o == 3'd3) && (rec_mod_o == 2'b01)
      |-> rec_disp_o[15:8] == {8{rec_disp_o[7]}});

  p_regmode_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && (rec_class_o == 3'd2) && (rec_mod_o == 2'b11) |-> rec_len_o == 3'd2);
endmodule

bind insn_byte_parser ibp_checker u_ibp_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .in_ready_o     (in_ready_o),
  .rec_valid_o    (rec_valid_o),
  .rec_ready_i    (rec_ready_i),
  .rec_class_o    (rec_class_o),
  .rec_opcode_o   (rec_opcode_o),
  .rec_mod_o      (rec_mod_o),
  .rec_reg_valid_o(rec_reg_valid_o),
  .rec_disp_o     (rec_disp_o),
  .rec_imm_o      (rec_imm_o),
  .rec_len_o      (rec_len_o)
);

// File: tb/insn_byte_parser_tb_top.sv
`timescale 1ns/1ps
module insn_byte_parser_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_byte_i = '0;
  logic        in_ready_o;
  logic        rec_valid_o;
  logic        rec_ready_i = 1'b1;
  logic [2:0]  rec_class_o;
  logic [5:0]  rec_opcode_o;
  logic        rec_dir_o, rec_wide_o;
  logic [1:0]  rec_mod_o;
  logic [2:0]  rec_reg_o, rec_rm_o;
  logic        rec_reg_valid_o;
  logic [15:0] rec_disp_o, rec_imm_o;
  logic [2:0]  rec_len_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  insn_byte_parser dut_i (.*);

  typedef logic [7:0] bq_t[$];
  typedef struct {
    logic [2:0] cls; logic [5:0] op; logic d, w;
    logic [1:0] md; logic [2:0] rg, rm; logic rv;
    logic [15:0] disp, imm; logic [2:0] len;
  } exp_t;

  exp_t sb[$];
  int   n_run = 0, n_fail = 0;
  int   rdy_mode = 0, gap_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  bit   done = 0;

  task automatic chk(string req, string fld, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, fld, act, exp);
    end
  endtask

  // Expected record derived from the requirement text
  function automatic exp_t ref_decode(bq_t q);
    exp_t e;
    int   i, dn, inn;
    logic [7:0] b;
    b = q[0];
    e = '{default: '0};
    e.op = b[7:2]; e.d = b[1]; e.w = b[0];
    if (b < 8'h40)                      e.cls = (b[2] == 1'b0) ? 3'd2 : (b[2:1] == 2'b10 ? 3'd4 : 3'd0);
    else if (b < 8'h60)                 e.cls = 3'd1;
    else if (b >= 8'h90 && b <= 8'h97)  e.cls = 3'd1;
    else if (b >= 8'h80 && b <= 8'h83)  e.cls = 3'd3;
    else if (b == 8'hC6 || b == 8'hC7)  e.cls = 3'd3;
    else if (b >= 8'h84 && b <= 8'h8B)  e.cls = 3'd2;
    else if (b >= 8'hA0 && b <= 8'hA3)  e.cls = 3'd5;
    else                                e.cls = 3'd0;
    i = 1; dn = 0;
    if (e.cls == 3'd1) e.rg = b[2:0];
    e.rv = (e.cls == 3'd1) || (e.cls == 3'd2);
    if (e.cls == 3'd2 || e.cls == 3'd3) begin
      e.md = q[1][7:6]; e.rg = q[1][5:3]; e.rm = q[1][2:0];
      i = 2;
      if (e.md == 2'b01) dn = 1;
      else if (e.md == 2'b10) dn = 2;
      else if (e.md == 2'b00 && e.rm == 3'b110) dn = 2;
    end
    if (e.cls == 3'd5) dn = 2;
    if (dn == 1) e.disp = {{8{q[i][7]}}, q[i]};
    if (dn == 2) e.disp = {q[i+1], q[i]};
    i += dn;
    inn = (e.cls == 3'd3 || e.cls == 3'd4) ? (e.w ? 2 : 1) : 0;
    if (inn == 1) e.imm = {8'h00, q[i]};
    if (inn == 2) e.imm = {q[i+1], q[i]};
    e.len = 3'(i + inn);
    return e;
  endfunction

  // Caller enters just after a rising edge
  task automatic push_byte(logic [7:0] b, bit last);
    in_valid_i = 1'b1; in_byte_i = b;
    forever begin @(negedge clk_i); if (in_ready_o) break; end
    @(posedge clk_i); #1;
    in_valid_i = 1'b0;
    if (last) begin
      @(negedge clk_i);
      chk("R13", "valid after last byte", 16'(rec_valid_o), 16'd1);
      @(posedge clk_i); #1;
    end
    if (gap_mode != 0 && lfsr[2]) begin @(posedge clk_i); #1; end
  endtask

  task automatic run_insn(bq_t q);
    exp_t e;
    e = ref_decode(q);
    if (int'(e.len) != q.size()) begin
      n_run++; n_fail++;
      $display("FAIL R9 vector length: actual %0d expected %0d", q.size(), e.len);
    end
    sb.push_back(e);
    foreach (q[k]) push_byte(q[k], k == q.size() - 1);
  endtask

  // Record consumer handshake
  initial begin
    forever begin
      @(posedge clk_i); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rec_ready_i = (rdy_mode == 0) ? 1'b1 : lfsr[0];
    end
  end

  // Scoreboard monitor
  logic        held = 0;
  logic [15:0] h_disp, h_imm; logic [2:0] h_len;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (rec_valid_o) chk("R10", "in_ready while record held", 16'(in_ready_o), 16'd0);
      if (held && rec_valid_o) begin
        chk("R10", "held disp", rec_disp_o, h_disp);
        chk("R10", "held imm", rec_imm_o, h_imm);
        chk("R10", "held len", 16'(rec_len_o), 16'(h_len));
      end
      held = rec_valid_o && !rec_ready_i;
      h_disp = rec_disp_o; h_imm = rec_imm_o; h_len = rec_len_o;
      if (rec_valid_o && rec_ready_i) begin
        if (sb.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R10 unexpected record: actual len %0d expected none", rec_len_o);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk("R2", "class", 16'(rec_class_o), 16'(e.cls));
          chk("R1", "opcode", 16'(rec_opcode_o), 16'(e.op));
          chk("R1", "dir", 16'(rec_dir_o), 16'(e.d));
          chk("R1", "wide", 16'(rec_wide_o), 16'(e.w));
          chk((e.cls == 3'd2 || e.cls == 3'd3) ? "R3" : "R12", "mod", 16'(rec_mod_o), 16'(e.md));
          chk((e.cls == 3'd2 || e.cls == 3'd3) ? "R3" : "R12", "rm", 16'(rec_rm_o), 16'(e.rm));
          chk((e.cls == 3'd1) ? "R6" : "R3", "reg", 16'(rec_reg_o), 16'(e.rg));
          chk("R7", "reg_valid", 16'(rec_reg_valid_o), 16'(e.rv));
          chk((e.cls == 3'd5) ? "R8" : "R4", "disp", rec_disp_o, e.disp);
          chk("R5", "imm", rec_imm_o, e.imm);
          chk("R9", "len", 16'(rec_len_o), 16'(e.len));
        end
      end
    end
  end

  task automatic run_set();
    run_insn('{8'h88, 8'hC1});
    run_insn('{8'h8B, 8'h07});
    run_insn('{8'h8B, 8'h46, 8'hF0});
    run_insn('{8'h8B, 8'h46, 8'h12});
    run_insn('{8'h89, 8'h87, 8'h34, 8'h12});
    run_insn('{8'h8B, 8'h06, 8'h78, 8'h56});
    run_insn('{8'h43});
    run_insn('{8'h95});
    run_insn('{8'hF4});
    run_insn('{8'h04, 8'h7F});
    run_insn('{8'h05, 8'hCD, 8'hAB});
    run_insn('{8'h81, 8'h86, 8'h34, 8'h12, 8'h78, 8'h56});
    run_insn('{8'h80, 8'hEB, 8'h05});
    run_insn('{8'hC7, 8'h46, 8'hFE, 8'h34, 8'h12});
    run_insn('{8'hA1, 8'h00, 8'h20});
    run_insn('{8'hC6, 8'h06, 8'h10, 8'h00, 8'hAA});
    run_insn('{8'h01, 8'h58, 8'h80});
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11", "in_ready after reset", 16'(in_ready_o), 16'd1);
    chk("R11", "rec_valid after reset", 16'(rec_valid_o), 16'd0);
    @(posedge clk_i); #1;

    // R1 R3: the two fixed examples
    run_set();

    // Abandon an instruction midway with reset (R11)
    push_byte(8'h8B, 0);
    push_byte(8'h46, 0);
    rst_ni = 1'b0;
    @(posedge clk_i); #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11", "in_ready after mid reset", 16'(in_ready_o), 16'd1);
    chk("R11", "rec_valid after mid reset", 16'(rec_valid_o), 16'd0);
    @(posedge clk_i); #1;
    run_insn('{8'h88, 8'hC1});

    // Consumer stalls and input gaps (R10)
    rdy_mode = 1; gap_mode = 1;
    run_set();
    run_set();

    while (sb.size() != 0) @(posedge clk_i);
    repeat (4) @(posedge clk_i);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule